// File: doc/BRIEF.md
# Privileged Core Event Counter Bank

This block is a bank of four 32-bit event counters that sits beside a processor core. Each counter has its own local control register. That register picks one event from a 7-bit event code and says in which process contexts the counter may advance. A single global control register holds a freeze bit that stops the whole bank at once. Shared event codes reach any counter. Counter-private codes reach only the counter that owns them.

Software reaches the bank through a simple register port with an enable, a write strobe, an address, write data and a privilege flag. Read data and the error flag are combinational in the same cycle. A write takes effect at the next clock edge. The lower half of the address space is the privileged space, and only a supervisor-mode access may use it. The upper half, selected by the top address bit, is a read-only mirror that any privilege level may read. Counting is qualified per process by a mark bit taken from the machine state. An external gating input can also qualify counting when a counter asks for it.

Top module: `pmon_core_bank`

## Requirements
- R1: After reset every counter and every local control register reads 0, and the global control register reads 1 (frozen).
- R2: A counter adds exactly one in a cycle where its selected event is high and all of its gating conditions hold, and it wraps from 0xFFFFFFFF to 0.
- R3: Codes 0 to 63 are shared: code c selects shared_evt[c] on whichever counter is programmed with it.
- R4: Codes 64+j are counter-private: on counter k they select spec_evt[k*16+j] for j < 16. Codes 64+j with j >= 16 never count.
- R5: Local control bit 8 allows counting while proc_mark is 1, and bit 9 allows counting while proc_mark is 0. Bits [6:0] hold the event code.
- R6: When local control bit 10 is set, the counter advances only in cycles where ext_gate is 1.
- R7: Global control bit 0 set freezes all counters. After a write clears it, counting resumes with the very next cycle.
- R8: A supervisor write to the privileged space updates the addressed register at the next edge. A counter write overrides an event in the same cycle. Offsets 0-3 are the counters, 4-7 the local controls, and 8 the global control. Local control bits other than [10:8] and [6:0] read as 0.
- R9: A write from user mode, or any write aimed at the mirror space (address bit 4 set), raises acc_err and leaves every register unchanged.
- R10: A read of the mirror space at offset n returns the same value as the privileged register at offset n, whatever the privilege level.
- R11: A user-mode access to the privileged space raises acc_err, and so does any access to an offset above 8. In both cases acc_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shared_evt | input | 64 | Event pulses that any counter may select |
| spec_evt | input | 64 | Counter-private event pulses, 16 per counter |
| proc_mark | input | 1 | Process mark bit from the machine state |
| ext_gate | input | 1 | External counting qualifier |
| acc_en | input | 1 | Register access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sup | input | 1 | 1 = supervisor-mode access |
| acc_addr | input | 5 | Bit 4 selects the mirror space, bits [3:0] the offset |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the same cycle |
| acc_err | output | 1 | Access refused |

## Verification
On every cycle the assertions check that a counter never moves by more than one without a write, and that it holds still while frozen. They also check that a written value lands, that refused writes leave the control state untouched, that refused accesses return zero data, and that an invalid private code never produces an event hit. Event selection across shared and private codes, the mark and external gating combinations, wrap-around and resumption right after unfreeze can only be shown by the bench. Its scenarios compare the readback on every clock against a behavioural model of the bank.

// File: rtl/pmon_pkg.sv
package pmon_pkg;

  localparam int EVT_W    = 7;
  localparam int SHARED_N = 64;

  typedef struct packed {
    logic             gate_en;
    logic             en_mclr;
    logic             en_mset;
    logic [EVT_W-1:0] evsel;
  } lctl_t;

  function automatic lctl_t lctl_from_word(input logic [31:0] w);
    lctl_t l;
    l.gate_en = w[10];
    l.en_mclr = w[9];
    l.en_mset = w[8];
    l.evsel   = w[EVT_W-1:0];
    return l;
  endfunction

  function automatic logic [31:0] lctl_to_word(input lctl_t l);
    logic [31:0] w;
    w = '0;
    w[10] = l.gate_en;
    w[9]  = l.en_mclr;
    w[8]  = l.en_mset;
    w[EVT_W-1:0] = l.evsel;
    return w;
  endfunction

  function automatic logic count_ok(input lctl_t l, input logic mark,
                                    input logic ext, input logic frozen);
    logic ctx_ok;
    ctx_ok = mark ? l.en_mset : l.en_mclr;
    return !frozen && ctx_ok && (!l.gate_en || ext);
  endfunction

endpackage

// File: rtl/pmon_evt_sel.sv
module pmon_evt_sel
  import pmon_pkg::*;
#(
  parameter int SPEC_N = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [EVT_W-1:0]    evsel,
  input  logic [SHARED_N-1:0] shared_evt,
  input  logic [SPEC_N-1:0]   own_spec,
  output logic                hit
);

  logic [5:0] code_lo;
  assign code_lo = evsel[5:0];

  always_comb begin
    hit = 1'b0;
    if (!evsel[6]) begin
      hit = shared_evt[code_lo];
    end else begin
      for (int j = 0; j < SPEC_N; j++) begin
        if (code_lo == 6'(j)) hit = own_spec[j];
      end
    end
  end

  p_bad_private_no_hit_r4: assert property (@(posedge clk) disable iff (rst)
    (evsel[6] && (int'(code_lo) >= SPEC_N)) |-> !hit);

endmodule

// File: rtl/pmon_counter.sv
module pmon_counter #(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             wr_en,
  input  logic [CTR_W-1:0] wr_data,
  input  logic             freeze,
  output logic [CTR_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (wr_en) cnt <= wr_data;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  p_step_le_one_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  p_frozen_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (freeze && !wr_en) |=> $stable(cnt));

  p_wr_lands_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cnt == $past(wr_data));

endmodule

// File: rtl/pmon_regport.sv
module pmon_regport
  import pmon_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 32,
  parameter int ADDR_W  = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          acc_en,
  input  logic                          acc_wr,
  input  logic                          acc_sup,
  input  logic [ADDR_W-1:0]             acc_addr,
  input  logic [CTR_W-1:0]              acc_wdata,
  input  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_all,
  output lctl_t [NUM_CTR-1:0]           lctl_q,
  output logic                          freeze_q,
  output logic [NUM_CTR-1:0]            ctr_wr,
  output logic [CTR_W-1:0]              acc_rdata,
  output logic                          acc_err
);

  localparam int OFF_W = ADDR_W - 1;
  localparam int OFF_G = 2 * NUM_CTR;

  logic             in_mirror;
  logic [OFF_W-1:0] off;
  logic             mapped;
  logic             acc_ok;
  logic             wr_go;
  logic [31:0]      wword;
  logic             unused_wbits;

  assign in_mirror = acc_addr[ADDR_W-1];
  assign off       = acc_addr[OFF_W-1:0];
  assign mapped    = (off <= OFF_W'(OFF_G));
  assign acc_ok    = acc_en && mapped && (in_mirror ? !acc_wr : acc_sup);
  assign acc_err   = acc_en && !acc_ok;
  assign wr_go     = acc_ok && acc_wr;
  assign wword     = 32'(acc_wdata);
  assign unused_wbits = ^acc_wdata;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctl
    assign ctr_wr[i] = wr_go && (off == OFF_W'(i));

    always_ff @(posedge clk) begin
      if (rst)
        lctl_q[i] <= '0;
      else if (wr_go && off == OFF_W'(NUM_CTR + i))
        lctl_q[i] <= lctl_from_word(wword);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      freeze_q <= 1'b1;
    else if (wr_go && off == OFF_W'(OFF_G))
      freeze_q <= acc_wdata[0];
  end

  always_comb begin
    acc_rdata = '0;
    if (acc_ok && !acc_wr) begin
      for (int i = 0; i < NUM_CTR; i++) begin
        if (off == OFF_W'(i))           acc_rdata = cnt_all[i];
        if (off == OFF_W'(NUM_CTR + i)) acc_rdata = CTR_W'(lctl_to_word(lctl_q[i]));
      end
      if (off == OFF_W'(OFF_G)) acc_rdata = CTR_W'(freeze_q);
    end
  end

  p_user_wr_ctl_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_wr && !acc_sup) |=> ($stable(lctl_q) && $stable(freeze_q)));

  p_user_wr_no_ctr_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_wr && !acc_sup) |-> (ctr_wr == '0));

  p_mirror_wr_err_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_wr && in_mirror) |-> (acc_err && ctr_wr == '0));

  p_gctl_lands_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_wr && acc_sup && !in_mirror && off == OFF_W'(OFF_G))
      |=> freeze_q == $past(acc_wdata[0]));

  p_err_zero_data_r11: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> (acc_rdata == '0));

endmodule

// File: rtl/pmon_core_bank.sv
module pmon_core_bank
  import pmon_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 32,
  parameter int SPEC_N  = 16,
  parameter int ADDR_W  = $clog2(2 * NUM_CTR + 1) + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [SHARED_N-1:0]       shared_evt,
  input  logic [NUM_CTR*SPEC_N-1:0] spec_evt,
  input  logic                      proc_mark,
  input  logic                      ext_gate,
  input  logic                      acc_en,
  input  logic                      acc_wr,
  input  logic                      acc_sup,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic [CTR_W-1:0]          acc_wdata,
  output logic [CTR_W-1:0]          acc_rdata,
  output logic                      acc_err
);

  lctl_t [NUM_CTR-1:0]           lctl_q;
  logic                          freeze_q;
  logic [NUM_CTR-1:0]            ctr_wr;
  logic [NUM_CTR-1:0]            evt_hit;
  logic [NUM_CTR-1:0]            ctr_inc;
  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_all;

  pmon_regport #(
    .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .acc_sup  (acc_sup),
    .acc_addr (acc_addr),
    .acc_wdata(acc_wdata),
    .cnt_all  (cnt_all),
    .lctl_q   (lctl_q),
    .freeze_q (freeze_q),
    .ctr_wr   (ctr_wr),
    .acc_rdata(acc_rdata),
    .acc_err  (acc_err)
  );

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    pmon_evt_sel #(.SPEC_N(SPEC_N)) u_sel (
      .clk       (clk),
      .rst       (rst),
      .evsel     (lctl_q[k].evsel),
      .shared_evt(shared_evt),
      .own_spec  (spec_evt[k*SPEC_N +: SPEC_N]),
      .hit       (evt_hit[k])
    );

    assign ctr_inc[k] = evt_hit[k] && count_ok(lctl_q[k], proc_mark, ext_gate, freeze_q);

    pmon_counter #(.CTR_W(CTR_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .inc    (ctr_inc[k]),
      .wr_en  (ctr_wr[k]),
      .wr_data(acc_wdata),
      .freeze (freeze_q),
      .cnt    (cnt_all[k])
    );
  end

  p_frozen_no_inc_r7: assert property (@(posedge clk) disable iff (rst)
    freeze_q |-> (ctr_inc == '0));

  p_gate_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    !ext_gate |-> ((ctr_inc & {NUM_CTR{1'b1}}) == (ctr_inc & ~gate_mask())));

  function automatic logic [NUM_CTR-1:0] gate_mask();
    logic [NUM_CTR-1:0] m;
    for (int k = 0; k < NUM_CTR; k++) m[k] = lctl_q[k].gate_en;
    return m;
  endfunction

endmodule

// File: tb/pmon_core_bank_tb.sv
module pmon_core_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] shared_evt;
  logic [63:0] spec_evt;
  logic        proc_mark;
  logic        ext_gate;
  logic        acc_en, acc_wr, acc_sup;
  logic [4:0]  acc_addr;
  logic [31:0] acc_wdata;
  logic [31:0] acc_rdata;
  logic        acc_err;

  int total = 0;
  int bad   = 0;
  int rot   = 0;

  logic [31:0] m_cnt  [4];
  logic [31:0] m_lctl [4];
  logic        m_frz;

  always #10 clk = ~clk;

  pmon_core_bank dut_i (
    .clk(clk), .rst(rst), .shared_evt(shared_evt), .spec_evt(spec_evt),
    .proc_mark(proc_mark), .ext_gate(ext_gate), .acc_en(acc_en),
    .acc_wr(acc_wr), .acc_sup(acc_sup), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_err(acc_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_value(input int off);
    if (off < 4)  return m_cnt[off];
    if (off < 8)  return m_lctl[off-4];
    return {31'b0, m_frz};
  endfunction

  function automatic logic m_ok();
    int off;
    off = int'(acc_addr[3:0]);
    if (!acc_en || off > 8) return 1'b0;
    return acc_addr[4] ? !acc_wr : acc_sup;
  endfunction

  function automatic logic m_event(input int k);
    int code;
    code = int'(m_lctl[k][6:0]);
    if (code < 64) return shared_evt[code];
    if (code - 64 < 16) return spec_evt[k*16 + code - 64];
    return 1'b0;
  endfunction

  task automatic m_update();
    logic ok;
    int off;
    ok  = m_ok();
    off = int'(acc_addr[3:0]);
    for (int k = 0; k < 4; k++) begin
      logic ctx;
      ctx = proc_mark ? m_lctl[k][8] : m_lctl[k][9];
      if (!m_frz && ctx && (!m_lctl[k][10] || ext_gate) && m_event(k))
        m_cnt[k] = m_cnt[k] + 32'd1;
    end
    if (ok && acc_wr) begin
      if (off < 4)      m_cnt[off] = acc_wdata;
      else if (off < 8) m_lctl[off-4] = acc_wdata & 32'h0000_077F;
      else              m_frz = acc_wdata[0];
    end
  endtask

  task automatic step(input string req);
    logic ok;
    #1;
    ok = m_ok();
    if (acc_en) begin
      chk({req, " err"}, {31'b0, acc_err}, {31'b0, !ok});
      if (!acc_wr)
        chk({req, " rdata"}, acc_rdata, ok ? m_value(int'(acc_addr[3:0])) : 32'h0);
    end
    @(posedge clk);
    m_update();
    @(negedge clk);
  endtask

  task automatic wr(input logic sup, input logic [4:0] a, input logic [31:0] d, input string req);
    acc_en = 1'b1; acc_wr = 1'b1; acc_sup = sup; acc_addr = a; acc_wdata = d;
    step(req);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(input logic sup, input logic [4:0] a, input string req, output logic [31:0] d);
    shared_evt = '0; spec_evt = '0;
    acc_en = 1'b1; acc_wr = 1'b0; acc_sup = sup; acc_addr = a; acc_wdata = '0;
    #1;
    d = acc_rdata;
    step(req);
    acc_en = 1'b0;
  endtask

  // mode 0: random events, mark and gate; mode 1: all events high, mark/gate held
  task automatic idle(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      if (mode == 0) begin
        shared_evt = {$urandom, $urandom};
        spec_evt   = {$urandom, $urandom};
        proc_mark  = $urandom_range(0, 1);
        ext_gate   = $urandom_range(0, 1);
      end else begin
        shared_evt = '1; spec_evt = '1;
      end
      acc_en = 1'b1; acc_wr = 1'b0; acc_sup = 1'b0;
      acc_addr = 5'(16 + (rot % 4)); acc_wdata = '0;
      rot++;
      step("R10 mirror vs model");
      acc_en = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, b;
    rst = 1'b1; shared_evt = '0; spec_evt = '0; proc_mark = 1'b0; ext_gate = 1'b0;
    acc_en = 1'b0; acc_wr = 1'b0; acc_sup = 1'b0; acc_addr = '0; acc_wdata = '0;
    for (int k = 0; k < 4; k++) begin m_cnt[k] = '0; m_lctl[k] = '0; end
    m_frz = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    for (int a = 0; a < 9; a++) begin
      rd(1'b1, 5'(a), "R1 reset", v);
      chk("R1 literal", v, (a == 8) ? 32'd1 : 32'd0);
    end

    // R8 configuration writes, R4 private codes, R6 gated counter
    wr(1'b1, 5'd4, 32'h0000_0305, "R8 lctl0");
    wr(1'b1, 5'd5, 32'h0000_0343, "R8 lctl1 private 3");
    wr(1'b1, 5'd6, 32'h0000_0354, "R8 lctl2 private 20");
    wr(1'b1, 5'd7, 32'hFFFF_F507, "R8 lctl3 gated");
    rd(1'b1, 5'd7, "R8 lctl mask", v);
    chk("R8 lctl readback", v, 32'h0000_0507);
    wr(1'b1, 5'd8, 32'h0, "R7 unfreeze");
    idle(60, 0);
    rd(1'b1, 5'd2, "R4 invalid private", v);
    chk("R4 invalid private never counts", v, 32'h0);
    rd(1'b1, 5'd1, "R4 valid private", v);
    chk("R4 private counter advanced", {31'b0, v != 0}, 32'd1);

    // R5 mark enables
    wr(1'b1, 5'd4, 32'h0000_0205, "R5 lctl0 mark-clear only");
    rd(1'b1, 5'd0, "R5 before", b);
    proc_mark = 1'b1; ext_gate = 1'b1;
    idle(5, 1);
    rd(1'b1, 5'd0, "R5 mark set", v);
    chk("R5 mark set no count", v, b);
    proc_mark = 1'b0;
    idle(5, 1);
    rd(1'b1, 5'd0, "R5 mark clear", v);
    chk("R5 mark clear counts", v, b + 32'd5);

    // R6 external gate
    proc_mark = 1'b1; ext_gate = 1'b0;
    rd(1'b1, 5'd3, "R6 before", b);
    idle(4, 1);
    rd(1'b1, 5'd3, "R6 gate low", v);
    chk("R6 gate low holds", v, b);
    ext_gate = 1'b1;
    idle(4, 1);
    rd(1'b1, 5'd3, "R6 gate high", v);
    chk("R6 gate high counts", v, b + 32'd4);

    // R7 freeze and resume
    proc_mark = 1'b0;
    wr(1'b1, 5'd8, 32'h1, "R7 freeze");
    rd(1'b1, 5'd0, "R7 before", b);
    idle(6, 1);
    rd(1'b1, 5'd0, "R7 frozen", v);
    chk("R7 frozen holds", v, b);
    wr(1'b1, 5'd8, 32'h0, "R7 unfreeze");
    idle(1, 1);
    rd(1'b1, 5'd0, "R7 resumed", v);
    chk("R7 resumes next cycle", v, b + 32'd1);

    // R2 wrap
    wr(1'b1, 5'd0, 32'hFFFF_FFFF, "R2 preset");
    idle(1, 1);
    rd(1'b1, 5'd0, "R2 wrap", v);
    chk("R2 wraps to zero", v, 32'h0);

    // R8 write beats event
    idle(1, 1);
    wr(1'b1, 5'd1, 32'd100, "R8 write with event");
    rd(1'b1, 5'd1, "R8 write wins", v);
    chk("R8 write overrides increment", v, 32'd100);

    // R9 refused writes
    wr(1'b0, 5'd8, 32'h1, "R9 user write gctl");
    idle(2, 1);
    rd(1'b0, 5'd24, "R9 gctl after user write", v);
    chk("R9 user write ignored", v, 32'h0);
    wr(1'b1, 5'd24, 32'h1, "R9 mirror write");
    rd(1'b0, 5'd24, "R9 gctl after mirror write", v);
    chk("R9 mirror write ignored", v, 32'h0);
    wr(1'b0, 5'd0, 32'd5, "R9 user counter write");
    rd(1'b1, 5'd0, "R9 counter after user write", v);
    chk("R9 counter not written", {31'b0, v == 32'd5}, 32'd0);

    // R11 refused reads
    acc_en = 1'b1; acc_wr = 1'b0; acc_sup = 1'b0; acc_addr = 5'd0; #1;
    chk("R11 user priv read err", {31'b0, acc_err}, 32'd1);
    chk("R11 user priv read data", acc_rdata, 32'h0);
    acc_sup = 1'b1; acc_addr = 5'd12; #1;
    chk("R11 unmapped err", {31'b0, acc_err}, 32'd1);
    step("R11 unmapped");
    acc_en = 1'b0;

    // R3 shared code on two counters
    wr(1'b1, 5'd4, 32'h0000_0305, "R3 lctl0");
    wr(1'b1, 5'd6, 32'h0000_0305, "R3 lctl2 same code");
    wr(1'b1, 5'd0, 32'h0, "R3 clr0");
    wr(1'b1, 5'd2, 32'h0, "R3 clr2");
    idle(20, 0);
    rd(1'b1, 5'd0, "R3 c0", b);
    rd(1'b1, 5'd2, "R3 c2", v);
    chk("R3 shared code same on both", v, b);

    // R10 mirror equals privileged
    rd(1'b1, 5'd5, "R10 priv", b);
    rd(1'b0, 5'd21, "R10 mirror", v);
    chk("R10 mirror matches", v, b);

    idle(100, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule